// File: doc/BRIEF.md
# Pipeline Forwarding and Interlock Unit

This block holds the hazard-control logic of a five-stage in-order integer pipeline (fetch, decode, execute, memory, writeback). It is purely combinational. Each cycle it looks at the source register numbers of the instruction in decode and of the instruction in execute. It compares them with the destination numbers held in the execute/memory and memory/writeback pipeline registers, and from that it tells the datapath where each operand must come from.

Two kinds of output come out of it. The first is a select code for each ALU input multiplexer and for the multiplexer feeding the branch zero-test, which sits in decode. The second is a stall, which freezes the program counter and the fetch/decode register and turns the execute-stage entry into a no-op. Only read-after-write dependences are tracked. Registers are read in decode and written in writeback, so write-after-read and write-after-write conflicts cannot arise.

The register file writes in the first half of a cycle. A value being written back can therefore be read in decode in the same cycle without any bypass. Register 0 always reads as zero and never takes part in a match.

Top module: `hazard_bypass_unit`

## Requirements
- R1: An ALU result in the execute/memory register whose destination equals an execute-stage source (not register 0) selects code 1 (execute/memory bypass) for that ALU input, so a dependent instruction directly behind an ALU instruction runs without a stall. Code 0 means register file, code 2 means memory/writeback bypass.
- R2: A match between an execute-stage source and the memory/writeback destination, with no execute/memory match, selects code 2 for that ALU input.
- R3: When both pipeline registers hold the same destination as an execute-stage source, the younger one (execute/memory, code 1) wins.
- R4: A load in execute whose destination is read as an operand by the instruction in decode raises a stall for exactly one cycle. A load in execute/memory is never bypassed as code 1.
- R5: A load, then an unrelated instruction, then a user of the load's result needs no stall; the user gets code 2.
- R6: Register 0 never causes a bypass code other than 0, a stall or a branch bypass.
- R7: A branch in decode whose tested register is written by the ALU instruction directly ahead stalls one cycle. After that the branch select is 1 (execute/memory bypass); otherwise it is 0 (register file).
- R8: A branch whose tested register is written by a load directly ahead stalls two cycles, then reads the register file (branch select 0). With one instruction between them it stalls one cycle.
- R9: During a stall, the PC hold, fetch/decode hold and execute bubble outputs are all 1; otherwise all are 0.
- R10: A writeback to the register that decode reads in the same cycle causes neither a stall nor a bypass (branch select 0).
- R11: A load-destination match on a decode source that the instruction does not use as an operand raises no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (used by the embedded checks) |
| rst_n | input | 1 | Synchronous active-low reset for the checks |
| id_rs1 | input | REG_AW | First source of the decode instruction (also the branch test register) |
| id_rs2 | input | REG_AW | Second source of the decode instruction |
| id_use_rs1 | input | 1 | Decode instruction reads rs1 as an ALU operand |
| id_use_rs2 | input | 1 | Decode instruction reads rs2 as an ALU operand |
| id_is_branch | input | 1 | Decode instruction is a zero-test branch on rs1 |
| ex_rs1 | input | REG_AW | First source of the execute instruction |
| ex_rs2 | input | REG_AW | Second source of the execute instruction |
| ex_rd | input | REG_AW | Destination of the execute instruction |
| ex_wr_en | input | 1 | Execute instruction writes a register |
| ex_is_load | input | 1 | Execute instruction is a load |
| mem_rd | input | REG_AW | Destination held in the execute/memory register |
| mem_wr_en | input | 1 | That instruction writes a register |
| mem_is_load | input | 1 | That instruction is a load |
| wb_rd | input | REG_AW | Destination held in the memory/writeback register |
| wb_wr_en | input | 1 | That instruction writes a register |
| alu_a_sel | output | 2 | Source code for ALU input A (0 file, 1 ex/mem, 2 mem/wb) |
| alu_b_sel | output | 2 | Source code for ALU input B |
| br_sel | output | 2 | Source code for the branch zero-test (0 file, 1 ex/mem) |
| pc_hold | output | 1 | Freeze the program counter |
| ifid_hold | output | 1 | Freeze the fetch/decode register |
| idex_bubble | output | 1 | Clear the control bits entering execute |

## Verification
The embedded checks watch, on every cycle, properties that need no history. A loaded value is never bypassed from execute/memory, register 0 never leaves the register-file select, and a branch bypass never comes from a load. Every stall has a real producer behind it, and with no writer in execute or memory there is no stall. Stall lengths (one cycle for a load user, one or two for a branch) and the choice of the younger producer only show up when instruction sequences move through a pipeline. The bench drives such sequences through its own behavioural pipeline, compares every output on each cycle, and counts the stall cycles of each sequence.

// File: rtl/fwd_pkg.sv
// Package: shared encodings for the forwarding and interlock unit.
// Assumes a two-bit multiplexer select at each operand input.
package fwd_pkg;
    // Where an operand is taken from.
    typedef enum logic [1:0] {
        SRC_RF    = 2'd0,
        SRC_EXMEM = 2'd1,
        SRC_MEMWB = 2'd2
    } opnd_src_e;

    // Number of ALU operand inputs served by the bypass network.
    localparam int unsigned NUM_ALU_SRC = 2;
endpackage

// File: rtl/reg_match.sv
// Module: reg_match
// Flags that a pending write targets a given source register.
// Assumes register 0 is hardwired to zero and so never matches.
module reg_match #(
    parameter int unsigned AW = 5
) (
    input  logic          wr_en,
    input  logic [AW-1:0] dst,
    input  logic [AW-1:0] src,
    output logic          hit
);
    localparam logic [AW-1:0] ZERO_REG = '0;

    // Compare destination with source, excluding the zero register.
    always_comb begin
        hit = wr_en && (dst != ZERO_REG) && (dst == src);
    end
endmodule

// File: rtl/ex_bypass_sel.sv
// Module: ex_bypass_sel
// Picks the source of one ALU operand for the instruction in execute.
// Assumes a load in the memory stage never feeds execute directly,
// since the interlock keeps its consumer back one cycle.
module ex_bypass_sel
    import fwd_pkg::*;
#(
    parameter int unsigned AW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] src,
    input  logic [AW-1:0] mem_rd,
    input  logic          mem_wr_en,
    input  logic          mem_is_load,
    input  logic [AW-1:0] wb_rd,
    input  logic          wb_wr_en,
    output opnd_src_e     sel
);
    logic mem_hit;
    logic wb_hit;

    reg_match #(.AW(AW)) u_mem_cmp (
        .wr_en (mem_wr_en && !mem_is_load),
        .dst   (mem_rd),
        .src   (src),
        .hit   (mem_hit)
    );

    reg_match #(.AW(AW)) u_wb_cmp (
        .wr_en (wb_wr_en),
        .dst   (wb_rd),
        .src   (src),
        .hit   (wb_hit)
    );

    // Younger producer first, then the older one, else the register file.
    always_comb begin
        if (mem_hit) begin
            sel = SRC_EXMEM;
        end else if (wb_hit) begin
            sel = SRC_MEMWB;
        end else begin
            sel = SRC_RF;
        end
    end

    // A loaded value is not yet present in the execute/memory register.
    p_load_not_bypassed_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_en && mem_is_load && (mem_rd == src)) |-> (sel != SRC_EXMEM));

    // The zero register always reads from the file.
    p_zero_reg_file_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (src == '0) |-> (sel == SRC_RF));

    // A bypass code is only chosen when some producer names this source.
    p_bypass_has_producer_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SRC_MEMWB) |-> (wb_wr_en && (wb_rd == src)));

    // The younger ALU producer wins over an older match.
    p_younger_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_en && !mem_is_load && (mem_rd == src) && (src != '0))
            |-> (sel == SRC_EXMEM));
endmodule

// File: rtl/id_interlock.sv
// Module: id_interlock
// Decides whether the decode instruction must wait, and where the
// branch zero-test takes its register from.
// Assumes the register file writes before it is read in a cycle, so a
// writeback producer never needs a bypass or a stall.
module id_interlock
    import fwd_pkg::*;
#(
    parameter int unsigned AW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] id_rs1,
    input  logic [AW-1:0] id_rs2,
    input  logic          id_use_rs1,
    input  logic          id_use_rs2,
    input  logic          id_is_branch,
    input  logic [AW-1:0] ex_rd,
    input  logic          ex_wr_en,
    input  logic          ex_is_load,
    input  logic [AW-1:0] mem_rd,
    input  logic          mem_wr_en,
    input  logic          mem_is_load,
    output logic          stall,
    output opnd_src_e     br_sel
);
    logic ex_hit_rs1;
    logic ex_hit_rs2;
    logic mem_hit_rs1;
    logic load_use;
    logic br_wait;

    reg_match #(.AW(AW)) u_ex_cmp1 (
        .wr_en (ex_wr_en),
        .dst   (ex_rd),
        .src   (id_rs1),
        .hit   (ex_hit_rs1)
    );

    reg_match #(.AW(AW)) u_ex_cmp2 (
        .wr_en (ex_wr_en),
        .dst   (ex_rd),
        .src   (id_rs2),
        .hit   (ex_hit_rs2)
    );

    reg_match #(.AW(AW)) u_mem_cmp1 (
        .wr_en (mem_wr_en),
        .dst   (mem_rd),
        .src   (id_rs1),
        .hit   (mem_hit_rs1)
    );

    // Load directly ahead of an operand or branch consumer.
    always_comb begin
        load_use = ex_is_load &&
                   ((ex_hit_rs1 && (id_use_rs1 || id_is_branch)) ||
                    (ex_hit_rs2 && id_use_rs2));
    end

    // Branch in decode whose register is not yet ready for the zero-test.
    always_comb begin
        br_wait = id_is_branch &&
                  (ex_hit_rs1 || (mem_hit_rs1 && mem_is_load));
    end

    // Combine both interlock causes.
    always_comb begin
        stall = load_use || br_wait;
    end

    // Branch operand from execute/memory when an ALU result is youngest there.
    always_comb begin
        if (id_is_branch && mem_hit_rs1 && !mem_is_load && !ex_hit_rs1) begin
            br_sel = SRC_EXMEM;
        end else begin
            br_sel = SRC_RF;
        end
    end

    // A stall always has a writer in execute, or a load in memory for a branch.
    p_stall_has_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> (ex_wr_en || (id_is_branch && mem_wr_en && mem_is_load)));

    // A branch bypass never delivers a load result.
    p_branch_bypass_alu_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (br_sel == SRC_EXMEM) |-> (id_is_branch && !mem_is_load && mem_wr_en));

    // A branch on register 0 never waits.
    p_branch_zero_free_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (id_is_branch && (id_rs1 == '0) && !id_use_rs2) |-> !stall);
endmodule

// File: rtl/hazard_bypass_unit.sv
// Module: hazard_bypass_unit
// Top of the forwarding and interlock unit for a five-stage in-order
// pipeline: ALU operand selects for execute, a branch operand select
// for decode, and one stall that freezes fetch and bubbles execute.
// Assumes inputs from empty stages are driven with write enables low.
module hazard_bypass_unit
    import fwd_pkg::*;
#(
    parameter int unsigned REG_AW = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_AW-1:0] id_rs1,
    input  logic [REG_AW-1:0] id_rs2,
    input  logic              id_use_rs1,
    input  logic              id_use_rs2,
    input  logic              id_is_branch,
    input  logic [REG_AW-1:0] ex_rs1,
    input  logic [REG_AW-1:0] ex_rs2,
    input  logic [REG_AW-1:0] ex_rd,
    input  logic              ex_wr_en,
    input  logic              ex_is_load,
    input  logic [REG_AW-1:0] mem_rd,
    input  logic              mem_wr_en,
    input  logic              mem_is_load,
    input  logic [REG_AW-1:0] wb_rd,
    input  logic              wb_wr_en,
    output logic [1:0]        alu_a_sel,
    output logic [1:0]        alu_b_sel,
    output logic [1:0]        br_sel,
    output logic              pc_hold,
    output logic              ifid_hold,
    output logic              idex_bubble
);
    logic [REG_AW-1:0] ex_src [NUM_ALU_SRC];
    opnd_src_e         ex_sel [NUM_ALU_SRC];
    opnd_src_e         id_br_sel;
    logic              freeze;

    // Gather the execute-stage sources into an indexable array.
    always_comb begin
        ex_src[0] = ex_rs1;
        ex_src[1] = ex_rs2;
    end

    // One bypass selector per ALU operand input.
    for (genvar g = 0; g < NUM_ALU_SRC; g++) begin : g_alu_src
        ex_bypass_sel #(.AW(REG_AW)) u_sel (
            .clk         (clk),
            .rst_n       (rst_n),
            .src         (ex_src[g]),
            .mem_rd      (mem_rd),
            .mem_wr_en   (mem_wr_en),
            .mem_is_load (mem_is_load),
            .wb_rd       (wb_rd),
            .wb_wr_en    (wb_wr_en),
            .sel         (ex_sel[g])
        );
    end

    id_interlock #(.AW(REG_AW)) u_interlock (
        .clk          (clk),
        .rst_n        (rst_n),
        .id_rs1       (id_rs1),
        .id_rs2       (id_rs2),
        .id_use_rs1   (id_use_rs1),
        .id_use_rs2   (id_use_rs2),
        .id_is_branch (id_is_branch),
        .ex_rd        (ex_rd),
        .ex_wr_en     (ex_wr_en),
        .ex_is_load   (ex_is_load),
        .mem_rd       (mem_rd),
        .mem_wr_en    (mem_wr_en),
        .mem_is_load  (mem_is_load),
        .stall        (freeze),
        .br_sel       (id_br_sel)
    );

    // Drive the selects and the three freeze controls.
    always_comb begin
        alu_a_sel   = ex_sel[0];
        alu_b_sel   = ex_sel[1];
        br_sel      = id_br_sel;
        pc_hold     = freeze;
        ifid_hold   = freeze;
        idex_bubble = freeze;
    end

    // With no writer in execute or memory there is nothing to wait for.
    p_no_writer_no_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!ex_wr_en && !mem_wr_en) |-> !pc_hold);

    // A decode instruction that reads nothing and is no branch never waits.
    p_unused_src_free_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!id_use_rs1 && !id_use_rs2 && !id_is_branch) |-> !idex_bubble);

    // Select codes stay within the three legal values.
    p_sel_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_a_sel != 2'd3) && (alu_b_sel != 2'd3) && (br_sel[1] == 1'b0));
endmodule

// File: tb/test_hazard_bypass_unit.sv
// Bench: a behavioural five-stage pipeline feeds the unit, and the
// expected outputs come from a youngest-producer search over the stages.
module test_hazard_bypass_unit;
    typedef struct packed {
        logic       v;
        logic [4:0] rd;
        logic [4:0] rs1;
        logic [4:0] rs2;
        logic       u1;
        logic       u2;
        logic       wr;
        logic       ld;
        logic       br;
    } ins_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [4:0] id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, mem_rd, wb_rd;
    logic id_use_rs1, id_use_rs2, id_is_branch, ex_wr_en, ex_is_load;
    logic mem_wr_en, mem_is_load, wb_wr_en;
    logic [1:0] alu_a_sel, alu_b_sel, br_sel;
    logic pc_hold, ifid_hold, idex_bubble;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    ins_t prog [$];

    always #10 clk = ~clk;

    hazard_bypass_unit #(.REG_AW(5)) i_hazard_bypass_unit (
        .clk(clk), .rst_n(rst_n),
        .id_rs1(id_rs1), .id_rs2(id_rs2), .id_use_rs1(id_use_rs1),
        .id_use_rs2(id_use_rs2), .id_is_branch(id_is_branch),
        .ex_rs1(ex_rs1), .ex_rs2(ex_rs2), .ex_rd(ex_rd),
        .ex_wr_en(ex_wr_en), .ex_is_load(ex_is_load),
        .mem_rd(mem_rd), .mem_wr_en(mem_wr_en), .mem_is_load(mem_is_load),
        .wb_rd(wb_rd), .wb_wr_en(wb_wr_en),
        .alu_a_sel(alu_a_sel), .alu_b_sel(alu_b_sel), .br_sel(br_sel),
        .pc_hold(pc_hold), .ifid_hold(ifid_hold), .idex_bubble(idex_bubble)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic ins_t mk(int rd, int rs1, int rs2, bit u1, bit u2, bit wr, bit ld, bit br);
        ins_t i;
        i.v = 1'b1; i.rd = 5'(rd); i.rs1 = 5'(rs1); i.rs2 = 5'(rs2);
        i.u1 = u1; i.u2 = u2; i.wr = wr; i.ld = ld; i.br = br;
        return i;
    endfunction

    function automatic ins_t alu(int rd, int a, int b); return mk(rd, a, b, 1, 1, 1, 0, 0); endfunction
    function automatic ins_t lw(int rd, int a);         return mk(rd, a, 0, 1, 0, 1, 1, 0); endfunction
    function automatic ins_t bz(int a);                 return mk(0, a, 0, 0, 0, 0, 0, 1); endfunction

    // 1 = execute, 2 = memory, 3 = writeback, 0 = none; youngest first.
    function automatic int youngest(logic [4:0] r, ins_t e, ins_t m, ins_t w);
        if (r == 5'd0) return 0;
        if (e.v && e.wr && e.rd == r) return 1;
        if (m.v && m.wr && m.rd == r) return 2;
        if (w.v && w.wr && w.rd == r) return 3;
        return 0;
    endfunction

    function automatic int exp_alu(logic [4:0] r, ins_t m, ins_t w);
        int y = youngest(r, '0, m, w);
        if (y == 2) return m.ld ? 0 : 1;
        if (y == 3) return 2;
        return 0;
    endfunction

    function automatic string alu_tag(int e, logic [4:0] r, ins_t w);
        if (e == 1) return (w.v && w.wr && w.rd == r) ? "R3" : "R1";
        if (e == 2) return "R2";
        return (r == 5'd0) ? "R6" : "R5";
    endfunction

    task automatic drive(ins_t d, ins_t e, ins_t m, ins_t w);
        id_rs1 = d.rs1; id_rs2 = d.rs2; id_use_rs1 = d.u1; id_use_rs2 = d.u2;
        id_is_branch = d.br;
        ex_rs1 = e.rs1; ex_rs2 = e.rs2; ex_rd = e.rd; ex_wr_en = e.wr; ex_is_load = e.ld;
        mem_rd = m.rd; mem_wr_en = m.wr; mem_is_load = m.ld;
        wb_rd = w.rd; wb_wr_en = w.wr;
    endtask

    // Run the program in prog through the model; compare every cycle.
    task automatic run_prog(input string req, input int exp_stalls);
        ins_t d = '0, e = '0, m = '0, w = '0;
        int pc = 0;
        int stalls = 0;
        bit st = 1'b0;
        do begin
            @(posedge clk);
            w = m; m = e;
            if (st) begin
                e = '0;
            end else begin
                e = d;
                d = (pc < prog.size()) ? prog[pc] : '0;
                if (pc < prog.size()) pc++;
            end
            drive(d, e, m, w);
            @(negedge clk);
            begin
                bit es = 1'b0;
                int ebr = 0;
                int ea, eb, yb;
                string stag;
                if (d.u1 && youngest(d.rs1, e, m, w) == 1 && e.ld) es = 1'b1;
                if (d.u2 && youngest(d.rs2, e, m, w) == 1 && e.ld) es = 1'b1;
                stag = "R4";
                if (d.br) begin
                    yb = youngest(d.rs1, e, m, w);
                    if (yb == 1) begin es = 1'b1; stag = e.ld ? "R8" : "R7"; end
                    if (yb == 2 && m.ld) begin es = 1'b1; stag = "R8"; end
                    if (yb == 2 && !m.ld) ebr = 1;
                end
                ea = exp_alu(e.rs1, m, w);
                eb = exp_alu(e.rs2, m, w);
                chk(alu_a_sel == 2'(ea), alu_tag(ea, e.rs1, w), alu_a_sel, ea);
                chk(alu_b_sel == 2'(eb), alu_tag(eb, e.rs2, w), alu_b_sel, eb);
                chk(br_sel == 2'(ebr), "R7", br_sel, ebr);
                chk(pc_hold == es, stag, pc_hold, es);
                chk(ifid_hold == es && idex_bubble == es, "R9",
                    {ifid_hold, idex_bubble}, {es, es});
                st = es;
                if (es) stalls++;
            end
        end while (pc < prog.size() || d.v || e.v || m.v || w.v);
        chk(stalls == exp_stalls, req, stalls, exp_stalls);
        prog.delete();
    endtask

    initial begin
        drive('0, '0, '0, '0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        // Reset state: nothing pending gives file selects and no stall.
        chk(alu_a_sel == 0 && alu_b_sel == 0 && br_sel == 0, "R9", alu_a_sel, 0);
        chk(!pc_hold && !ifid_hold && !idex_bubble, "R9", pc_hold, 0);
        rst_n = 1'b1;

        // R10: writeback and decode touch the same register in one cycle.
        @(posedge clk);
        drive(bz(3), '0, '0, alu(3, 1, 2));
        @(negedge clk);
        chk(br_sel == 0 && !pc_hold, "R10", {br_sel, pc_hold}, 0);

        // R1 R2 R10: ALU result used by the next three instructions.
        prog.push_back(alu(1, 2, 3)); prog.push_back(alu(4, 1, 3));
        prog.push_back(alu(6, 1, 7)); prog.push_back(alu(8, 1, 9));
        run_prog("R1", 0);
        // R4: load then dependent instruction.
        prog.push_back(lw(1, 2)); prog.push_back(alu(4, 1, 6));
        run_prog("R4", 1);
        // R5: load, unrelated, dependent.
        prog.push_back(lw(1, 2)); prog.push_back(alu(5, 2, 3)); prog.push_back(alu(4, 6, 1));
        run_prog("R5", 0);
        // R7: ALU then branch on its result.
        prog.push_back(alu(1, 2, 3)); prog.push_back(bz(1));
        run_prog("R7", 1);
        // R8: load then branch on its result.
        prog.push_back(lw(1, 2)); prog.push_back(bz(1));
        run_prog("R8", 2);
        // R8: load, unrelated, branch.
        prog.push_back(lw(1, 2)); prog.push_back(alu(5, 2, 3)); prog.push_back(bz(1));
        run_prog("R8", 1);
        // R6: zero register everywhere.
        prog.push_back(alu(0, 2, 3)); prog.push_back(alu(4, 0, 0));
        prog.push_back(lw(0, 2)); prog.push_back(alu(5, 0, 0)); prog.push_back(bz(0));
        run_prog("R6", 0);
        // R3: two producers of the same register.
        prog.push_back(alu(1, 2, 3)); prog.push_back(alu(1, 1, 4)); prog.push_back(alu(5, 1, 1));
        run_prog("R3", 0);
        // R11: load destination named but not used as an operand.
        prog.push_back(lw(1, 2)); prog.push_back(mk(7, 1, 1, 0, 0, 1, 0, 0));
        run_prog("R11", 0);
        // R4: load feeding the second operand only.
        prog.push_back(lw(9, 2)); prog.push_back(alu(4, 3, 9)); prog.push_back(bz(4));
        run_prog("R4", 2);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule